// File: doc/BRIEF.md
# Main Oscillator Failure Detector

This block watches a fast main oscillator clock and judges it against a slow RC reference clock. A small counter runs on the fast clock. The counter is cleared while the reference clock is low and counts while it is high. At each falling edge of the reference clock the block decides whether enough fast edges arrived during that high phase. A stopped or badly slowed oscillator therefore shows up within one reference period.

The decision crosses into the system clock domain. There it drives a live failure status bit, a sticky event flag that a status read clears, and an interrupt gated by a mask. On the rising edge of a failure the block latches fallback controls. The main clock source is steered to the internal fast RC oscillator and that oscillator is kept enabled. If the main source was the crystal and the master clock was taken from the PLL, the master clock select is also steered to the main clock. These fallback controls are outputs only; the clock multiplexers themselves sit outside the block.

Detection runs only while both the detector enable and the main oscillator enable are high. The first two reference periods after it starts are used to settle, and no failure is reported during them.

Top module: `osc_fail_monitor`

## Requirements
- R1: After reset, fail_status, fail_event and irq are 0, and mck_sel_o, main_xtal_o and rc_en_o equal cfg_mck_sel, cfg_main_xtal and cfg_rc_en.
- R2: While active, a main clock that gives at least MIN_EDGES (8) rising edges in every slow_clk high phase keeps fail_status at 0. After recovery from a failure, fail_status returns to 0 within three slow_clk periods.
- R3: While active, a main clock that is stopped, or gives fewer than 8 edges per high phase, sets fail_status and fail_event within three slow_clk periods once the settling window is over.
- R4: When det_en or osc_en is 0, fail_status and fail_event never rise and the select outputs follow the configuration inputs.
- R5: No failure is reported before the third slow_clk falling edge after the detector becomes active.
- R6: fail_event stays 1 after the main clock recovers, until a cycle with status_rd high clears it. A new failure edge in the same cycle wins over the read.
- R7: irq is 1 exactly when fail_event is 1 and irq_en is 1.
- R8: status_rd does not clear fail_status; fail_status follows the current verdict.
- R9: On a failure edge, if cfg_main_xtal is 1 and cfg_mck_sel is 2 (PLL; 0 is slow, 1 is main), mck_sel_o is forced to 1. Otherwise mck_sel_o keeps following cfg_mck_sel.
- R10: On a failure edge, main_xtal_o is forced to 0 (fast RC) and rc_en_o is forced to 1, whatever the configuration.
- R11: The forced controls stay latched until a cycle with cfg_wr high while fail_event is 0. A cfg_wr while fail_event is 1 does not release them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for status, event and fallback logic |
| rst_n | input | 1 | Active-low asynchronous core reset |
| main_clk | input | 1 | Main oscillator clock under watch |
| slow_clk | input | 1 | Slow RC reference clock |
| det_en | input | 1 | Detector enable |
| osc_en | input | 1 | Main oscillator enable; 0 turns the detector off |
| irq_en | input | 1 | Interrupt mask for the failure event |
| status_rd | input | 1 | Status read strobe; clears the event |
| cfg_wr | input | 1 | Clock-select configuration write strobe |
| cfg_main_xtal | input | 1 | Configured main source: 1 crystal, 0 fast RC |
| cfg_mck_sel | input | 2 | Configured master source: 0 slow, 1 main, 2 PLL |
| cfg_rc_en | input | 1 | Configured fast RC oscillator enable |
| fail_status | output | 1 | Live failure status |
| fail_event | output | 1 | Sticky failure event |
| irq | output | 1 | Failure interrupt |
| mck_sel_o | output | 2 | Effective master clock select |
| main_xtal_o | output | 1 | Effective main source select |
| rc_en_o | output | 1 | Effective fast RC enable |

## Verification
Every clock cycle, the assertions check the event flag's set, hold and clear rules, that a failure edge latches the fallback, and that a forced master select only comes from the crystal-plus-PLL setup. They also check that the latched controls survive any write made while the event is pending, and that the status stays low while the detector is off. The edge counting against the reference phase, the settling window, and recovery after a glitch-free restart need real clocks running at several rates. Only the bench scenarios show these, using a good, a slowed and a stopped main clock.

// File: rtl/osc_fail_monitor.sv
module osc_fail_monitor #(
  parameter int MIN_EDGES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_clk,
  input  logic       slow_clk,
  input  logic       det_en,
  input  logic       osc_en,
  input  logic       irq_en,
  input  logic       status_rd,
  input  logic       cfg_wr,
  input  logic       cfg_main_xtal,
  input  logic [1:0] cfg_mck_sel,
  input  logic       cfg_rc_en,
  output logic       fail_status,
  output logic       fail_event,
  output logic       irq,
  output logic [1:0] mck_sel_o,
  output logic       main_xtal_o,
  output logic       rc_en_o
);
  localparam int         CW       = $clog2(MIN_EDGES + 1);
  localparam logic [1:0] MCK_MAIN = 2'd1;
  localparam logic [1:0] MCK_PLL  = 2'd2;

  logic active_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= det_en & osc_en;

  // fast-clock edge counter, cleared asynchronously while the reference is low
  logic          run;
  logic [CW-1:0] edge_cnt;
  logic          enough;
  assign run    = slow_clk & active_q;
  assign enough = (edge_cnt == CW'(MIN_EDGES));

  always_ff @(posedge main_clk or negedge run)
    if (!run)        edge_cnt <= '0;
    else if (!enough) edge_cnt <= edge_cnt + 1'b1;

  // verdict at the end of each high phase, after a two-period settling window
  logic [1:0] warm;
  logic       verdict;
  always_ff @(negedge slow_clk or negedge active_q)
    if (!active_q) begin
      warm    <= 2'd0;
      verdict <= 1'b0;
    end else begin
      if (warm != 2'd2) warm <= warm + 2'd1;
      verdict <= (warm == 2'd2) && !enough;
    end

  logic [SYNC_STAGES-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], verdict};

  logic fail_now, fail_rise;
  assign fail_now  = sync_q[SYNC_STAGES-1] & active_q;
  assign fail_rise = fail_now & ~fail_status;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fail_status <= 1'b0;
    else        fail_status <= fail_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         fail_event <= 1'b0;
    else if (fail_rise) fail_event <= 1'b1;
    else if (status_rd) fail_event <= 1'b0;

  assign irq = fail_event & irq_en;

  // latched fallback controls
  logic frc_main, frc_rc, release_frc;
  assign release_frc = cfg_wr & ~fail_event;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frc_main <= 1'b0;
      frc_rc   <= 1'b0;
    end else if (fail_rise) begin
      frc_rc   <= 1'b1;
      frc_main <= frc_main | (cfg_main_xtal && cfg_mck_sel == MCK_PLL);
    end else if (release_frc) begin
      frc_rc   <= 1'b0;
      frc_main <= 1'b0;
    end

  assign mck_sel_o   = frc_main ? MCK_MAIN : cfg_mck_sel;
  assign main_xtal_o = cfg_main_xtal & ~frc_rc;
  assign rc_en_o     = cfg_rc_en | frc_rc;

  a_r3_event_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail_rise |=> fail_event && fail_status);
  a_r6_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fail_event && !status_rd |=> fail_event);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !fail_rise |=> !fail_event);
  a_r10_fallback_set: assert property (@(posedge clk) disable iff (!rst_n)
    fail_rise |=> !main_xtal_o && rc_en_o);
  a_r9_force_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frc_main) |-> $past(cfg_main_xtal && cfg_mck_sel == MCK_PLL));
  a_r11_force_held: assert property (@(posedge clk) disable iff (!rst_n)
    frc_rc && !(cfg_wr && !fail_event) |=> frc_rc);
  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !fail_status);
endmodule

// File: tb/sim_osc_fail_monitor.sv
`timescale 1ns/1ps
module sim_osc_fail_monitor;
  logic clk = 1'b0, rst_n = 1'b0, main_clk = 1'b0, slow_clk = 1'b0;
  logic det_en = 1'b0, osc_en = 1'b1, irq_en = 1'b1, status_rd = 1'b0, cfg_wr = 1'b0;
  logic cfg_main_xtal = 1'b1, cfg_rc_en = 1'b0;
  logic [1:0] cfg_mck_sel = 2'd2;
  logic fail_status, fail_event, irq, main_xtal_o, rc_en_o;
  logic [1:0] mck_sel_o;
  int checks = 0, errors = 0;
  int mper = 20;
  bit done = 0;

  osc_fail_monitor u0 (.*);

  always #2 clk = ~clk;
  initial begin #101; forever #200 slow_clk = ~slow_clk; end
  always begin
    if (mper == 0) begin main_clk = 1'b0; #5; end
    else begin #(mper / 2); main_clk = ~main_clk; end
  end

  logic [6:0] exp_q[$];
  string      tag_q[$];
  event       go;

  task automatic expect_state(string tag, bit fs, bit ev, bit ir, bit [1:0] mck, bit mx, bit rce);
    exp_q.push_back({fs, ev, ir, mck, mx, rce});
    tag_q.push_back(tag);
    ->go;
    #0;
  endtask

  task automatic cmp(string tag, string fld, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  initial forever begin
    @(go);
    while (exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "fail_status", fail_status, e[6]);
      cmp(t, "fail_event", fail_event, e[5]);
      cmp(t, "irq", irq, e[4]);
      cmp(t, "mck_sel_o", mck_sel_o, e[3:2]);
      cmp(t, "main_xtal_o", main_xtal_o, e[1]);
      cmp(t, "rc_en_o", rc_en_o, e[0]);
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_rd; status_rd = 1'b1; cyc(1); status_rd = 1'b0; cyc(1); endtask
  task automatic pulse_wr; cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0; cyc(1); endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    expect_state("R1 reset", 0, 0, 0, 2, 1, 0);
    det_en = 1'b1;
    cyc(500);
    expect_state("R2 good clock", 0, 0, 0, 2, 1, 0);
    det_en = 1'b0; mper = 0;
    cyc(400);
    expect_state("R4 det_en off", 0, 0, 0, 2, 1, 0);
    osc_en = 1'b0; det_en = 1'b1;
    cyc(400);
    expect_state("R4 osc_en off", 0, 0, 0, 2, 1, 0);
    osc_en = 1'b1;
    cyc(175);
    expect_state("R5 settling", 0, 0, 0, 2, 1, 0);
    cyc(250);
    expect_state("R3/R7/R9/R10 stopped clock", 1, 1, 1, 1, 0, 1);
    pulse_wr;
    expect_state("R11 write while pending", 1, 1, 1, 1, 0, 1);
    pulse_rd;
    expect_state("R6/R8 read clears event only", 1, 0, 0, 1, 0, 1);
    pulse_wr;
    expect_state("R11 release", 1, 0, 0, 2, 1, 0);
    mper = 20;
    cyc(300);
    expect_state("R2 recovery", 0, 0, 0, 2, 1, 0);
    irq_en = 1'b0; cfg_mck_sel = 2'd0; mper = 40;
    cyc(300);
    expect_state("R3/R7/R9 slow clock masked", 1, 1, 0, 0, 0, 1);
    mper = 20;
    cyc(300);
    expect_state("R6 sticky after recovery", 0, 1, 0, 0, 0, 1);
    irq_en = 1'b1;
    cyc(1);
    expect_state("R7 unmasked", 0, 1, 1, 0, 0, 1);
    pulse_rd;
    pulse_wr;
    expect_state("R6/R11 cleared", 0, 0, 0, 0, 1, 0);
    cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule